// File: doc/BRIEF.md
# DDR Read Burst Capture Sequencer

This block sits on the controller side of a double-data-rate SDRAM link. It takes a read request carrying a bank and a column, places a READ on the command/address outputs, and then uses the programmed CAS latency and burst length to open a capture window for the strobe and data that come back. The block runs on a fast clock at twice the command rate, so each fast cycle is one half-clock slot. A command therefore occupies two fast cycles, and the block takes one data word in each fast cycle that carries a strobe edge.

Once a burst has been captured, the words are presented side by side on a wide output with a one-cycle valid pulse. A new request is refused until the postamble of the current burst has finished. On every other slot the command output carries NOP.

Top module: `ddr_rd_capture`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cmd_out is NOP and rd_valid is low.
- R2: cmd_out uses the code {ras_n,cas_n,we_n}: NOP = 3'b111 and READ = 3'b101. It carries READ for exactly two consecutive fast cycles per accepted request and NOP on every other cycle.
- R3: A request is accepted at a rising edge where req_valid and req_ready are both high. READ then appears in the next fast cycle (slot 0), with bank_out and addr_out holding the request's bank and column, unchanged across both READ slots.
- R4: Counting from slot 0, the first data word is expected in slot 2*CL, where CL is cas_lat at acceptance and lies in the range 2 to 7. The strobe is expected low in slots 2*CL-2 and 2*CL-1.
- R5: Within the window, one word is captured in each slot in which dqs_in differs from its value in the previous slot. The word captured in window slot k goes to rd_data[k*DW +: DW].
- R6: The burst length is chosen by bl_sel at acceptance: 2'd2 gives 4 words, 2'd3 gives 8 words, and 2'd1 or 2'd0 gives 2 words. Slots of rd_data above the burst read as zero.
- R7: rd_valid is high for exactly one fast cycle, in slot 2*CL+BL+1, and only when all BL words of the window were captured.
- R8: If dqs_in is high in slot 2*CL-1 (a missing preamble), word 0 is not captured and rd_valid stays low for that burst.
- R9: Strobe edges and data outside slots 2*CL to 2*CL+BL-1 do not change any captured word.
- R10: req_ready is low from acceptance through slot 2*CL+BL+1. It is high again, on a command-phase cycle, no later than slot 2*CL+BL+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, two cycles per command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_bank | input | BA_W | Bank of the request |
| req_col | input | COL_W | Column of the request |
| cas_lat | input | CL_W | CAS latency in command clocks (2..7) |
| bl_sel | input | 2 | Burst length select |
| req_ready | output | 1 | Request can be accepted this cycle |
| cmd_out | output | 3 | {ras_n,cas_n,we_n} command |
| bank_out | output | BA_W | Bank address to memory |
| addr_out | output | COL_W | Column address to memory |
| dqs_in | input | 1 | Data strobe from memory |
| dq_in | input | DW | Data bus from memory |
| rd_valid | output | 1 | One-cycle pulse: burst complete |
| rd_data | output | MAX_BL*DW | Captured words, word k in slot k |

## Verification
If the slot counter were off, captured words would shift by one slot, or rd_valid would come a cycle early or late. A scoreboard catches either fault on the first burst. If the latched latency or burst length were wrong, the window would land on preamble or postamble slots and a word would be missed, so rd_valid would not appear in slot 2*CL+BL+1 of that burst. If the busy state cleared early or late, req_ready would be seen high during the postamble or stay low past slot 2*CL+BL+3, which is visible within a few cycles of the burst's end.

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
  parameter int DW     = 16,
  parameter int COL_W  = 10,
  parameter int BA_W   = 2,
  parameter int CL_W   = 3,
  parameter int MAX_BL = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [BA_W-1:0]       req_bank,
  input  logic [COL_W-1:0]      req_col,
  input  logic [CL_W-1:0]       cas_lat,
  input  logic [1:0]            bl_sel,
  output logic                  req_ready,
  output logic [2:0]            cmd_out,
  output logic [BA_W-1:0]       bank_out,
  output logic [COL_W-1:0]      addr_out,
  input  logic                  dqs_in,
  input  logic [DW-1:0]         dq_in,
  output logic                  rd_valid,
  output logic [MAX_BL*DW-1:0]  rd_data
);
  localparam logic [2:0] CMD_NOP  = 3'b111;
  localparam logic [2:0] CMD_READ = 3'b101;
  localparam int MAX_SLOT = 2 * ((1 << CL_W) - 1) + MAX_BL + 2;
  localparam int CNT_W    = $clog2(MAX_SLOT + 1);
  localparam int SLOT_W   = (MAX_BL > 1) ? $clog2(MAX_BL) : 1;

  logic             phase, busy, dqs_q;
  logic [CNT_W-1:0] cnt, wcnt, bl_q, first, last;
  logic [CL_W-1:0]  cl_q;
  logic             take, edge_seen, in_win;
  logic [SLOT_W-1:0] slot;

  function automatic logic [CNT_W-1:0] bl_decode(input logic [1:0] sel);
    case (sel)
      2'd3:    return CNT_W'(8);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(2);
    endcase
  endfunction

  assign req_ready = !busy && !phase;
  assign take      = req_valid && req_ready;
  assign cmd_out   = (busy && cnt < CNT_W'(2)) ? CMD_READ : CMD_NOP;
  assign first     = CNT_W'({cl_q, 1'b0});
  assign last      = first + bl_q - CNT_W'(1);
  assign in_win    = busy && cnt >= first && cnt <= last;
  assign edge_seen = dqs_in != dqs_q;
  assign slot      = SLOT_W'(cnt - first);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      busy     <= 1'b0;
      dqs_q    <= 1'b1;
      cnt      <= '0;
      wcnt     <= '0;
      bl_q     <= CNT_W'(2);
      cl_q     <= CL_W'(2);
      bank_out <= '0;
      addr_out <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      phase    <= ~phase;
      dqs_q    <= dqs_in;
      rd_valid <= busy && cnt == last + CNT_W'(1) && wcnt == bl_q;
      if (take) begin
        busy     <= 1'b1;
        cnt      <= '0;
        wcnt     <= '0;
        cl_q     <= cas_lat;
        bl_q     <= bl_decode(bl_sel);
        bank_out <= req_bank;
        addr_out <= req_col;
        rd_data  <= '0;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == last + CNT_W'(2)) busy <= 1'b0;
        if (in_win && edge_seen) begin
          rd_data[slot*DW +: DW] <= dq_in;
          wcnt <= wcnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ddr_rd_capture_chk.sv
module ddr_rd_capture_chk #(
  parameter int COL_W = 10,
  parameter int BA_W  = 2,
  parameter int CL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CL_W-1:0]  cas_lat,
  input logic [2:0]       cmd_out,
  input logic [BA_W-1:0]  bank_out,
  input logic [COL_W-1:0] addr_out,
  input logic             rd_valid
);
  localparam logic [2:0] NOP  = 3'b111;
  localparam logic [2:0] READ = 3'b101;

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_out == NOP || cmd_out == READ); // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cmd_out == NOP); // R10
  AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_out == READ); // R3
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == READ && $past(cmd_out) != READ) |=> cmd_out == READ); // R2
  AST_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == READ && $past(cmd_out) == READ) |=> cmd_out == NOP); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == READ && $past(cmd_out) == READ) |-> ($stable(addr_out) && $stable(bank_out))); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> cas_lat >= CL_W'(2)); // R4
endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.COL_W(COL_W), .BA_W(BA_W), .CL_W(CL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cas_lat(cas_lat), .cmd_out(cmd_out), .bank_out(bank_out),
  .addr_out(addr_out), .rd_valid(rd_valid)
);

// File: tb/ddr_rd_capture_test.sv
module ddr_rd_capture_test;
  localparam int PERIOD = 10;
  localparam int DW = 16, COL_W = 10, BA_W = 2, CL_W = 3, MAX_BL = 8;
  localparam logic [2:0] NOP = 3'b111, READ = 3'b101;

  logic clk = 0, rst_n = 0, req_valid = 0, dqs_in = 1;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [CL_W-1:0] cas_lat = 3'd3;
  logic [1:0] bl_sel = 2'd2;
  logic [DW-1:0] dq_in = '0;
  logic req_ready, rd_valid;
  logic [2:0] cmd_out;
  logic [BA_W-1:0] bank_out;
  logic [COL_W-1:0] addr_out;
  logic [MAX_BL*DW-1:0] rd_data;

  int tests = 0, fails = 0;
  logic [MAX_BL*DW-1:0] sb_q[$];

  ddr_rd_capture #(.DW(DW), .COL_W(COL_W), .BA_W(BA_W), .CL_W(CL_W), .MAX_BL(MAX_BL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_col(req_col), .cas_lat(cas_lat), .bl_sel(bl_sel), .req_ready(req_ready),
    .cmd_out(cmd_out), .bank_out(bank_out), .addr_out(addr_out), .dqs_in(dqs_in),
    .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [MAX_BL*DW-1:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) check("R8 unexpected rd_valid", 1, 0);
      else check("R5 R6 R9 burst data", rd_data, sb_q.pop_front());
    end
  end

  task automatic burst(input int cl, input logic [1:0] sel, input logic [BA_W-1:0] b,
                       input logic [COL_W-1:0] c, input bit bad_pre, input bit noise);
    int bl, fv, vt;
    logic [MAX_BL*DW-1:0] exp;
    bl = (sel == 2'd3) ? 8 : (sel == 2'd2) ? 4 : 2;
    fv = 2*cl;
    vt = fv + bl + 1;
    exp = '0;
    for (int k = 0; k < bl; k++) exp[k*DW +: DW] = DW'(16'hA500 ^ (cl << 8) ^ (k * 16'h0111) ^ c);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_bank = b; req_col = c; cas_lat = CL_W'(cl); bl_sel = sel;
    if (!bad_pre) sb_q.push_back(exp);
    @(negedge clk);
    req_valid = 0; cas_lat = 3'd7; bl_sel = 2'd0; req_col = ~c;
    for (int t = 0; t <= vt + 2; t++) begin
      if (t >= fv - 2 && t < fv) begin dqs_in = bad_pre; dq_in = 16'hBEEF; end
      else if (t >= fv && t < fv + bl) begin
        dqs_in = ~t[0]; dq_in = exp[(t-fv)*DW +: DW];
      end else if (t >= fv + bl && t < fv + bl + 2) begin dqs_in = 0; dq_in = 16'hDEAD; end
      else begin dqs_in = noise ? t[0] : 1'b1; dq_in = noise ? DW'(16'h5A5A + t) : '0; end
      if (t == 0) begin
        check("R3 READ in slot 0", cmd_out, READ);
        check("R3 bank/column", {bank_out, addr_out}, {b, c});
      end
      if (t == 1) check("R2 READ held in slot 1", {cmd_out, bank_out, addr_out}, {READ, b, c});
      if (t == 2) check("R2 NOP after READ", cmd_out, NOP);
      if (t == fv) check("R10 ready low in burst", req_ready, 0);
      if (t == vt - 1) check("R7 no early valid", rd_valid, 0);
      if (t == vt) begin
        check("R7 valid slot", rd_valid, !bad_pre);
        check("R10 ready low in postamble", req_ready, 0);
      end
      if (t == vt + 2) check("R10 ready back", req_ready, 1);
      @(negedge clk);
    end
    dqs_in = 1; dq_in = '0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cmd NOP in reset", cmd_out, NOP);
    check("R1 rd_valid low in reset", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 cmd NOP after reset", cmd_out, NOP);
    check("R1 rd_valid low after reset", rd_valid, 0);
    burst(3, 2'd2, 2'd1, 10'h155, 0, 0);   // R4 R5 CL3 BL4
    burst(2, 2'd1, 2'd2, 10'h00F, 0, 0);   // R6 BL2
    burst(3, 2'd3, 2'd3, 10'h3FF, 0, 0);   // R6 BL8
    burst(5, 2'd3, 2'd0, 10'h200, 0, 1);   // R9 noise outside window
    burst(7, 2'd0, 2'd1, 10'h0A5, 0, 0);   // R6 code 0 gives 2, R4 CL7
    burst(3, 2'd2, 2'd2, 10'h111, 1, 0);   // R8 bad preamble
    burst(4, 2'd2, 2'd3, 10'h321, 0, 1);   // recovery after bad preamble
    repeat (4) @(negedge clk);
    check("R7 scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule